// File: doc/BRIEF.md
# Text Window Raster Locator

This block sits in the dot-clock domain of an on-screen text overlay. It counts dot clocks from each horizontal sync strobe and scan lines from each vertical sync strobe. From these counts it reports whether the current dot lies inside a 24-column by 12-row grid of 12×18-dot glyph cells. When it does, it also gives the glyph cell (row, column) and the dot inside that glyph (dot_x, dot_y). Downstream logic uses these coordinates to fetch the character and the glyph pixel.

Two control words place and scale the grid. The horizontal word `h_ctrl` holds the left edge in units of four dot clocks and three 2-bit magnification codes. The vertical word `v_ctrl` holds the top edge in units of four scan lines and three codes of the same kind. The first code applies to row 0, the second to row 1, and the third to rows 2 through 11. Each row is 18 dots times its vertical magnification tall, and the next row follows with no gap. A separate enable blanks the window without stopping the walk.

Top module: `osd_raster_scaler`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after release with `text_en` low, `in_window` and every coordinate output are 0. Reset leaves every internal counter at the origin.
- R2: Call the cycle after an `hsync` cycle horizontal cycle 0. The first cycle of a line that is in the window is horizontal cycle 4·P, where P = `h_ctrl[5:0]`.
- R3: The cycles after a `vsync` cycle, up to the next `hsync` strobe, form line 0. Each `hsync` strobe starts the next line. The first line with a window is line 4·Q, where Q = `v_ctrl[5:0]`.
- R4: With horizontal code c for the current row, each `dot_x` value lasts c+1 cycles. `dot_x` runs 0 to 11, and `col` then advances. After column 23 the window stays closed for the rest of the line.
- R5: With vertical code c for the current row, each `dot_y` value lasts c+1 lines. `dot_y` runs 0 to 17, and `row` then advances to the next line group. After row 11 no window opens until the next `vsync`.
- R6: In both control words, bits 7:6 give the code for row 0, bits 9:8 the code for row 1, and bits 11:10 the code for rows 2 to 11. Code values 0, 1, 2 and 3 mean magnification 1, 2, 3 and 4.
- R7: While `text_en` is low, `in_window` is 0. The walk carries on unchanged, so coordinates seen after re-enabling are those of an uninterrupted walk.
- R8: A start field of 63 places the edge 252 cycles or 252 lines from the strobe, and the full grid still follows it.
- R9: Whenever `in_window` is 0, `row`, `col`, `dot_x` and `dot_y` are all 0.
- R10: An `hsync` strobe restarts the horizontal walk at any point, including mid-window, and `col` and `dot_x` are 0 in the next cycle. A `vsync` strobe restarts the vertical walk at any point, including mid-grid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync | input | 1 | One-cycle horizontal sync strobe |
| vsync | input | 1 | One-cycle vertical sync strobe |
| text_en | input | 1 | Window enable; low blanks the window |
| h_ctrl | input | 12 | [5:0] left edge /4, [7:6] [9:8] [11:10] horizontal codes |
| v_ctrl | input | 12 | [5:0] top edge /4, [7:6] [9:8] [11:10] vertical codes |
| in_window | output | 1 | Current dot lies inside the text grid |
| row | output | 4 | Glyph row 0..11 |
| col | output | 5 | Glyph column 0..23 |
| dot_x | output | 4 | Dot inside the glyph, 0..11 |
| dot_y | output | 5 | Glyph line inside the row, 0..17 |

## Verification
Every output is decoded combinationally from registered counters. A strobe or count edge sampled at a rising clock edge therefore shows in the coordinates during the cycle that follows it. `text_en` and the control words act within the same cycle. The bench drives inputs just after each falling edge and compares all five outputs at every falling edge. The reference model advances its dot and line counts at the rising edge, so each comparison covers exactly one cycle after a stimulus. The model places each row by summing row heights over the magnification codes, and it derives column and dot by division. The control words change only while the vertical walk has finished, so the model and the design never see a scale switch in the middle of a walk.

// File: rtl/osd_raster_pkg.sv
package osd_raster_pkg;
   localparam int SIZE_CODE_W  = 2;
   localparam int SIZE_GROUPS  = 3;
   typedef logic [SIZE_CODE_W-1:0] size_code_t;
endpackage

// File: rtl/osd_size_pick.sv
module osd_size_pick #(
   parameter int NUM_GROUPS = osd_raster_pkg::SIZE_GROUPS,
   parameter int CODE_W     = osd_raster_pkg::SIZE_CODE_W,
   parameter int IDX_W      = 4
) (
   input  logic [NUM_GROUPS*CODE_W-1:0] codes,
   input  logic [IDX_W-1:0]             idx,
   output logic [CODE_W-1:0]            code
);
   // the last group covers every row from NUM_GROUPS-1 upward
   always_comb begin
      code = codes[(NUM_GROUPS-1)*CODE_W +: CODE_W];
      for (int g = 0; g < NUM_GROUPS-1; g++) begin
         if (idx == IDX_W'(g)) code = codes[g*CODE_W +: CODE_W];
      end
   end
endmodule

// File: rtl/osd_axis_walker.sv
module osd_axis_walker #(
   parameter int CELL   = 12,
   parameter int CELLS  = 24,
   parameter int POS_W  = 8,
   localparam int DOT_W = $clog2(CELL),
   localparam int IDX_W = $clog2(CELLS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     restart,
   input  logic                     step,
   input  logic [POS_W-1:0]         start,
   input  osd_raster_pkg::size_code_t scale,
   output logic                     valid,
   output logic [IDX_W-1:0]         idx,
   output logic [DOT_W-1:0]         dot
);
   localparam logic [POS_W-1:0] POS_MAX = '1;

   logic [POS_W-1:0]                pos_q;
   logic                            run_q, done_q;
   osd_raster_pkg::size_code_t      rep_q;
   logic [DOT_W-1:0]                dot_q;
   logic [IDX_W-1:0]                idx_q;
   logic                            hit, last_rep, last_dot, last_idx;

   assign hit      = !run_q && !done_q && (pos_q == start);
   assign valid    = run_q || hit;
   assign last_rep = (rep_q == scale);
   assign last_dot = (dot_q == DOT_W'(CELL-1));
   assign last_idx = (idx_q == IDX_W'(CELLS-1));
   assign idx      = idx_q;
   assign dot      = dot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0; run_q <= 1'b0; done_q <= 1'b0;
         rep_q <= '0; dot_q <= '0;   idx_q  <= '0;
      end else if (restart) begin
         pos_q <= '0; run_q <= 1'b0; done_q <= 1'b0;
         rep_q <= '0; dot_q <= '0;   idx_q  <= '0;
      end else if (step) begin
         if (pos_q != POS_MAX) pos_q <= pos_q + POS_W'(1);
         if (valid) begin
            if (!last_rep) begin
               rep_q <= rep_q + 1'b1;
               run_q <= 1'b1;
            end else begin
               rep_q <= '0;
               if (!last_dot) begin
                  dot_q <= dot_q + DOT_W'(1);
                  run_q <= 1'b1;
               end else begin
                  dot_q <= '0;
                  if (!last_idx) begin
                     idx_q <= idx_q + IDX_W'(1);
                     run_q <= 1'b1;
                  end else begin
                     idx_q  <= '0;
                     run_q  <= 1'b0;
                     done_q <= 1'b1;
                  end
               end
            end
         end
      end
   end
endmodule

// File: rtl/osd_raster_scaler.sv
module osd_raster_scaler #(
   parameter int NUM_COLS      = 24,
   parameter int NUM_ROWS      = 12,
   parameter int GLYPH_W       = 12,
   parameter int GLYPH_H       = 18,
   parameter int POS_FIELD_W   = 6,
   parameter int POS_UNIT_LOG2 = 2,
   localparam int CODES_W = osd_raster_pkg::SIZE_GROUPS * osd_raster_pkg::SIZE_CODE_W,
   localparam int REG_W   = POS_FIELD_W + CODES_W,
   localparam int ROW_W   = $clog2(NUM_ROWS),
   localparam int COL_W   = $clog2(NUM_COLS),
   localparam int DX_W    = $clog2(GLYPH_W),
   localparam int DY_W    = $clog2(GLYPH_H)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hsync,
   input  logic             vsync,
   input  logic             text_en,
   input  logic [REG_W-1:0] h_ctrl,
   input  logic [REG_W-1:0] v_ctrl,
   output logic             in_window,
   output logic [ROW_W-1:0] row,
   output logic [COL_W-1:0] col,
   output logic [DX_W-1:0]  dot_x,
   output logic [DY_W-1:0]  dot_y
);
   localparam int START_W = POS_FIELD_W + POS_UNIT_LOG2;

   generate
      if (GLYPH_W < 2 || GLYPH_H < 2) begin : g_bad_glyph
         $error("glyph cell must be at least 2x2 dots");
      end
      if (NUM_COLS < 2 || NUM_ROWS < osd_raster_pkg::SIZE_GROUPS) begin : g_bad_grid
         $error("grid too small for the row size groups");
      end
      if (POS_FIELD_W < 1 || POS_UNIT_LOG2 < 0) begin : g_bad_pos
         $error("bad start position field");
      end
   endgenerate

   logic [START_W-1:0]                h_start, v_start;
   osd_raster_pkg::size_code_t        h_code, v_code;
   logic                              h_ok, v_ok;
   logic [COL_W-1:0]                  h_idx;
   logic [DX_W-1:0]                   h_dot;
   logic [ROW_W-1:0]                  v_idx;
   logic [DY_W-1:0]                   v_dot;

   assign h_start = START_W'(h_ctrl[POS_FIELD_W-1:0]) << POS_UNIT_LOG2;
   assign v_start = START_W'(v_ctrl[POS_FIELD_W-1:0]) << POS_UNIT_LOG2;

   osd_size_pick #(.IDX_W(ROW_W)) u_hpick (
      .codes(h_ctrl[REG_W-1:POS_FIELD_W]), .idx(v_idx), .code(h_code));
   osd_size_pick #(.IDX_W(ROW_W)) u_vpick (
      .codes(v_ctrl[REG_W-1:POS_FIELD_W]), .idx(v_idx), .code(v_code));

   osd_axis_walker #(.CELL(GLYPH_W), .CELLS(NUM_COLS), .POS_W(START_W)) u_hwalk (
      .clk(clk), .rst_n(rst_n), .restart(hsync), .step(1'b1),
      .start(h_start), .scale(h_code),
      .valid(h_ok), .idx(h_idx), .dot(h_dot));

   osd_axis_walker #(.CELL(GLYPH_H), .CELLS(NUM_ROWS), .POS_W(START_W)) u_vwalk (
      .clk(clk), .rst_n(rst_n), .restart(vsync), .step(hsync & ~vsync),
      .start(v_start), .scale(v_code),
      .valid(v_ok), .idx(v_idx), .dot(v_dot));

   assign in_window = rst_n & text_en & h_ok & v_ok;
   assign row   = in_window ? v_idx : '0;
   assign col   = in_window ? h_idx : '0;
   assign dot_x = in_window ? h_dot : '0;
   assign dot_y = in_window ? v_dot : '0;
endmodule

// File: rtl/osd_raster_scaler_chk.sv
module osd_raster_scaler_chk #(
   parameter int NUM_COLS = 24,
   parameter int NUM_ROWS = 12,
   parameter int GLYPH_W  = 12,
   parameter int GLYPH_H  = 18,
   localparam int ROW_W   = $clog2(NUM_ROWS),
   localparam int COL_W   = $clog2(NUM_COLS),
   localparam int DX_W    = $clog2(GLYPH_W),
   localparam int DY_W    = $clog2(GLYPH_H)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             hsync,
   input logic             vsync,
   input logic             text_en,
   input logic             in_window,
   input logic [ROW_W-1:0] row,
   input logic [COL_W-1:0] col,
   input logic [DX_W-1:0]  dot_x,
   input logic [DY_W-1:0]  dot_y
);
   // R4
   h_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_window |-> (col < COL_W'(NUM_COLS)) && (dot_x < DX_W'(GLYPH_W)));
   // R5
   v_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_window |-> (row < ROW_W'(NUM_ROWS)) && (dot_y < DY_W'(GLYPH_H)));
   // R7
   blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !text_en |-> !in_window);
   // R9
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_window |-> (row == '0) && (col == '0) && (dot_x == '0) && (dot_y == '0));
   // R10
   line_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hsync |=> (col == '0) && (dot_x == '0));
   // R4
   col_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_window && !hsync) |=> (!in_window || col >= $past(col)));
   // R5
   row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_window && !hsync && !vsync) |=> (!in_window || row == $past(row)));
endmodule

bind osd_raster_scaler osd_raster_scaler_chk #(
   .NUM_COLS(NUM_COLS), .NUM_ROWS(NUM_ROWS), .GLYPH_W(GLYPH_W), .GLYPH_H(GLYPH_H)
) u_chk (
   .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync), .text_en(text_en),
   .in_window(in_window), .row(row), .col(col), .dot_x(dot_x), .dot_y(dot_y)
);

// File: tb/osd_raster_scaler_bench.sv
module osd_raster_scaler_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hsync = 1'b0, vsync = 1'b0, text_en = 1'b0;
   logic [11:0] h_ctrl = '0, v_ctrl = '0;
   logic        in_window;
   logic [3:0]  row;
   logic [4:0]  col;
   logic [3:0]  dot_x;
   logic [4:0]  dot_y;

   int    checks = 0, failures = 0, cycles = 0;
   int    hc = 0, vl = 0;
   bit    chk_on = 0, finished = 0;
   string phase = "R1 reset";
   int    long_a, long_b, long_c, long_len, en_from, cut_line, cut_at;

   osd_raster_scaler u_osd_raster_scaler (
      .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync), .text_en(text_en),
      .h_ctrl(h_ctrl), .v_ctrl(v_ctrl), .in_window(in_window),
      .row(row), .col(col), .dot_x(dot_x), .dot_y(dot_y));

   always #2 clk = ~clk;

   // reference counters: dots since hsync, lines since vsync
   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         hc = 0; vl = 0;
      end else begin
         if (hsync) hc = 0; else hc++;
         if (vsync) vl = 0; else if (hsync) vl++;
      end
   end

   function automatic int mag(logic [11:0] w, int r);
      if (r == 0) return int'(w[7:6]) + 1;
      if (r == 1) return int'(w[9:8]) + 1;
      return int'(w[11:10]) + 1;
   endfunction

   always @(negedge clk) begin
      if (chk_on && !finished) begin
         int e_win, e_row, e_col, e_x, e_y, l, p, acc, rf, hs;
         e_win = 0; e_row = 0; e_col = 0; e_x = 0; e_y = 0;
         if (rst_n) begin
            l = vl - 4 * int'(v_ctrl[5:0]);
            rf = -1; acc = 0;
            if (l >= 0) begin
               for (int r = 0; r < 12; r++) begin
                  if (rf < 0 && l < acc + 18 * mag(v_ctrl, r)) begin
                     rf = r; e_y = (l - acc) / mag(v_ctrl, r);
                  end
                  acc += 18 * mag(v_ctrl, r);
               end
            end
            hs = mag(h_ctrl, (rf < 0) ? 0 : rf);
            p  = hc - 4 * int'(h_ctrl[5:0]);
            if (text_en && rf >= 0 && p >= 0 && p < 288 * hs) begin
               e_win = 1; e_row = rf; e_col = p / (12 * hs); e_x = (p / hs) % 12;
            end else begin
               e_y = 0;
            end
         end
         checks++;
         if (int'(in_window) != e_win || int'(row) != e_row || int'(col) != e_col ||
             int'(dot_x) != e_x || int'(dot_y) != e_y) begin
            failures++;
            $display("FAIL %s t=%0d: got win=%0d row=%0d col=%0d x=%0d y=%0d, expected win=%0d row=%0d col=%0d x=%0d y=%0d",
                     phase, cycles, in_window, row, col, dot_x, dot_y, e_win, e_row, e_col, e_x, e_y);
         end
      end
   end

   task automatic tick();
      @(negedge clk); #1;
   endtask

   task automatic line(int len, bit en, int cut);
      for (int i = 0; i < len; i++) begin
         tick();
         hsync   = (i == 0);
         text_en = en && !(cut > 0 && i >= cut);
      end
   endtask

   // an hsync, then new control words with vsync, then n lines
   task automatic frame(logic [11:0] h, logic [11:0] v, int n, int short_len);
      tick(); hsync = 1'b1; vsync = 1'b0;
      tick(); hsync = 1'b0; vsync = 1'b1; h_ctrl = h; v_ctrl = v;
      tick(); vsync = 1'b0;
      for (int k = 0; k < n; k++) begin
         line((k == long_a || k == long_b || k == long_c) ? long_len : short_len,
              k >= en_from, (k == cut_line) ? cut_at : 0);
      end
   endtask

   initial begin
      long_a = -1; long_b = -1; long_c = -1; long_len = 0;
      en_from = 0; cut_line = -1; cut_at = 0;
      chk_on = 1;
      repeat (4) tick();
      rst_n = 1'b1;               // R1: text_en still low here
      repeat (3) tick();
      text_en = 1'b1;

      phase = "R2 R3 R4 R5 frame A";
      long_a = 10; long_b = 11; long_len = 305;
      frame({2'd0, 2'd0, 2'd0, 6'd3}, {2'd0, 2'd0, 2'd0, 6'd2}, 230, 30);

      phase = "R6 frame B";
      long_a = 5; long_b = 40; long_c = 100; long_len = 1200;
      frame({2'd3, 2'd2, 2'd1, 6'd5}, {2'd3, 2'd2, 2'd1, 6'd0}, 815, 24);

      phase = "R7 R9 frame C";
      long_a = 12; long_b = -1; long_c = -1; long_len = 300;
      en_from = 10; cut_line = 12; cut_at = 150;
      frame({2'd0, 2'd0, 2'd0, 6'd1}, {2'd0, 2'd0, 2'd0, 6'd1}, 225, 20);

      phase = "R10 frame D";
      en_from = 0; cut_line = -1; long_a = 3; long_len = 700;
      frame({2'd1, 2'd1, 2'd1, 6'd0}, {2'd0, 2'd0, 2'd0, 6'd0}, 20, 40);
      long_a = -1;
      frame({2'd1, 2'd1, 2'd1, 6'd0}, {2'd0, 2'd0, 2'd0, 6'd0}, 225, 16);

      phase = "R8 frame E";
      long_a = 252; long_b = 300; long_len = 545;
      frame({2'd0, 2'd0, 2'd0, 6'd63}, {2'd0, 2'd0, 2'd0, 6'd63}, 470, 16);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   always @(posedge clk) begin
      if (cycles > 190000 && !finished) begin
         finished = 1;
         failures++;
         $display("FAIL watchdog expired in %s", phase);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule